// File: doc/BRIEF.md
# Registered Mixed-Sign 16x16 Multiplier

This block multiplies two 16-bit operands into a 32-bit product. Each operand has its own sign mode, so signed-by-signed, unsigned-by-unsigned and mixed products are all supported. The two operands sit in separately loaded input registers. The upper and lower product halves have their own output registers, each with its own load strobe. All loads are clock enables on one common clock. A synchronous active-low reset clears every register.

Before the result reaches the output registers, three optional steps shape it. A registered round bit adds a half-weight step at one of two positions. A fractional format mode shifts the product left by one place and puts the sign back into the top bit of the lower half. A bypass lets both halves flow straight from the formatter to the ports.

The upper port can carry either half. The lower port is shared with the Y operand bus. When its active-low enable is released, the port goes high-impedance and an external driver can place the next Y operand on it.

Top module: `opmul_top`

## Requirements
- R1: With fmt_adj=1 and the round bit clear, the 32-bit result is the low 32 bits of the exact product. X is read as two's complement when a_sgn=1 and as unsigned when a_sgn=0; b_sgn does the same for Y. The upper half is result bits 31..16 and the lower half is bits 15..0.
- R2: The X register loads a_in only on cycles with a_ld=1. The Y register loads lo_bus only on cycles with b_ld=1. Each register holds its value otherwise.
- R3: The round bit is a register that captures rnd_req on every cycle where a_ld or b_ld is 1. When it is set, 2^15 is added to the product if fmt_adj=1, or 2^14 if fmt_adj=0. The sum wraps modulo 2^32.
- R4: With fmt_adj=0 and s the rounded product, the result is {s[30:15], s[31], s[13:0], 1'b0}.
- R5: The upper output register loads the formatted upper half only when hi_ld=1. The lower output register loads the formatted lower half only when lo_ld=1. Neither register changes otherwise.
- R6: With bypass=1, both output halves follow the formatted product of the current operand registers with no output register delay. The output registers keep their contents and show again once bypass returns to 0.
- R7: With sel_lo=0 the upper port carries the upper half. With sel_lo=1 it carries the lower half.
- R8: The lower port drives the lower half only when lo_oe_n=0. The upper port drives only when hi_oe_n=0. Each port is high-impedance otherwise, and when lo_oe_n=1 the lower port serves as the Y input bus.
- R9: Reset clears both operand registers, the round bit and both output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | X operand input |
| a_ld | input | 1 | X register load (also captures the round bit) |
| b_ld | input | 1 | Y register load from lo_bus (also captures the round bit) |
| a_sgn | input | 1 | X mode: 1 two's complement, 0 unsigned |
| b_sgn | input | 1 | Y mode: 1 two's complement, 0 unsigned |
| rnd_req | input | 1 | Round request, captured with the operand loads |
| fmt_adj | input | 1 | 1 full product, 0 left-shifted fractional format |
| hi_ld | input | 1 | Upper output register load |
| lo_ld | input | 1 | Lower output register load |
| bypass | input | 1 | 1 routes the formatted product around the output registers |
| sel_lo | input | 1 | Upper port source: 0 upper half, 1 lower half |
| lo_oe_n | input | 1 | Active-low drive enable of lo_bus |
| hi_oe_n | input | 1 | Active-low drive enable of hi_bus |
| lo_bus | inout | 16 | Y operand input, or lower half output |
| hi_bus | output | 16 | Upper output port |

## Verification
A wrong Booth digit or sign extension affects only some operand and mode pairs, so the same code will give a wrong half on a few of them. The reference is the exact product of 33-bit extended operands, and all sixteen mode combinations are swept over corner operands, so such an error reaches the ports two cycles after the operand load. A round bit that is stale, at the wrong weight, or captured on the wrong strobe shows up as an offset of 2^14 or 2^15 in the next loaded result. A stuck or wrongly loaded output register shows up as a half that is mismatched or held, when the two load strobes, bypass and the half-select are exercised apart from one another.

// File: rtl/opmul_pkg.sv
package opmul_pkg;

   // one radix-4 recoded multiplier digit
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } bdig_t;

   function automatic bdig_t booth_dec(input logic [2:0] t);
      bdig_t d;
      d.neg = t[2] & ~(t[1] & t[0]);
      d.one = t[1] ^ t[0];
      d.two = (t == 3'b011) | (t == 3'b100);
      return d;
   endfunction

endpackage

// File: rtl/opmul_booth.sv
module opmul_booth #(
   parameter int W         = 16,
   parameter bit USE_BOOTH = 1'b1
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   input  logic           xs,
   input  logic           ys,
   output logic [2*W-1:0] p
);
   import opmul_pkg::*;

   localparam int PW   = 2 * W;
   localparam int YEW  = ((W + 2) / 2) * 2;
   localparam int NDIG = YEW / 2;

   if (W < 4) begin : g_bad_w
      $error("opmul_booth: W must be at least 4");
   end

   if (USE_BOOTH) begin : g_booth
      logic [YEW:0]  yx;
      logic [PW-1:0] xe;
      logic [PW-1:0] pp [NDIG];
      logic [PW-1:0] acc;

      assign yx = {{(YEW - W){ys & y[W-1]}}, y, 1'b0};
      assign xe = {{(PW - W){xs & x[W-1]}}, x};

      for (genvar i = 0; i < NDIG; i++) begin : g_pp
         bdig_t         d;
         logic [PW-1:0] mag;
         logic [PW-1:0] sgn;
         assign d   = booth_dec(yx[2*i+2 : 2*i]);
         assign mag = d.two ? (xe << 1) : (d.one ? xe : '0);
         assign sgn = d.neg ? (~mag + 1'b1) : mag;
         assign pp[i] = sgn << (2 * i);
      end

      always_comb begin
         acc = '0;
         for (int i = 0; i < NDIG; i++) acc = acc + pp[i];
      end
      assign p = acc;
   end else begin : g_direct
      logic signed [W:0]      xa;
      logic signed [W:0]      ya;
      logic signed [2*W+1:0]  pr;
      assign xa = {xs & x[W-1], x};
      assign ya = {ys & y[W-1], y};
      assign pr = xa * ya;
      assign p  = pr[PW-1:0];
   end

endmodule

// File: rtl/opmul_fmt.sv
module opmul_fmt #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] raw,
   input  logic           rnd,
   input  logic           fa,
   output logic [2*W-1:0] res
);
   localparam int PW = 2 * W;

   if (W < 4) begin : g_bad_w
      $error("opmul_fmt: W must be at least 4");
   end

   logic [PW-1:0] inc;
   logic [PW-1:0] rs;

   always_comb begin
      inc = '0;
      if (rnd) inc[fa ? (W - 1) : (W - 2)] = 1'b1;
   end

   assign rs  = raw + inc;
   assign res = fa ? rs : {rs[PW-2:W-1], rs[PW-1], rs[W-3:0], 1'b0};

endmodule

// File: rtl/opmul_outstage.sv
module opmul_outstage #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hi_ld,
   input  logic           lo_ld,
   input  logic           bypass,
   input  logic           sel_lo,
   input  logic [2*W-1:0] res,
   output logic [W-1:0]   hi_q,
   output logic [W-1:0]   lo_q,
   output logic [W-1:0]   msp,
   output logic [W-1:0]   lsp,
   output logic [W-1:0]   upper
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (hi_ld) hi_q <= res[2*W-1:W];
         if (lo_ld) lo_q <= res[W-1:0];
      end
   end

   assign msp   = bypass ? res[2*W-1:W] : hi_q;
   assign lsp   = bypass ? res[W-1:0]   : lo_q;
   assign upper = sel_lo ? lsp : msp;

endmodule

// File: rtl/opmul_top.sv
module opmul_top #(
   parameter int OPW       = 16,
   parameter bit USE_BOOTH = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [OPW-1:0] a_in,
   input  logic           a_ld,
   input  logic           b_ld,
   input  logic           a_sgn,
   input  logic           b_sgn,
   input  logic           rnd_req,
   input  logic           fmt_adj,
   input  logic           hi_ld,
   input  logic           lo_ld,
   input  logic           bypass,
   input  logic           sel_lo,
   input  logic           lo_oe_n,
   input  logic           hi_oe_n,
   inout  wire  [OPW-1:0] lo_bus,
   output logic [OPW-1:0] hi_bus
);
   localparam int PW = 2 * OPW;

   if (OPW < 4) begin : g_bad_w
      $error("opmul_top: OPW must be at least 4");
   end

   logic [OPW-1:0] a_q;
   logic [OPW-1:0] b_q;
   logic           rnd_q;
   logic [PW-1:0]  raw_w;
   logic [PW-1:0]  res_w;
   logic [OPW-1:0] hi_q_w;
   logic [OPW-1:0] lo_q_w;
   logic [OPW-1:0] msp_w;
   logic [OPW-1:0] lsp_w;
   logic [OPW-1:0] up_w;

   // operand registers and the round bit
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         rnd_q <= 1'b0;
      end else begin
         if (a_ld)         a_q   <= a_in;
         if (b_ld)         b_q   <= lo_bus;
         if (a_ld || b_ld) rnd_q <= rnd_req;
      end
   end

   opmul_booth #(.W(OPW), .USE_BOOTH(USE_BOOTH)) u_mul (
      .x  (a_q),
      .y  (b_q),
      .xs (a_sgn),
      .ys (b_sgn),
      .p  (raw_w)
   );

   opmul_fmt #(.W(OPW)) u_fmt (
      .raw (raw_w),
      .rnd (rnd_q),
      .fa  (fmt_adj),
      .res (res_w)
   );

   opmul_outstage #(.W(OPW)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_ld  (hi_ld),
      .lo_ld  (lo_ld),
      .bypass (bypass),
      .sel_lo (sel_lo),
      .res    (res_w),
      .hi_q   (hi_q_w),
      .lo_q   (lo_q_w),
      .msp    (msp_w),
      .lsp    (lsp_w),
      .upper  (up_w)
   );

   assign lo_bus = lo_oe_n ? {OPW{1'bz}} : lsp_w;
   assign hi_bus = hi_oe_n ? {OPW{1'bz}} : up_w;

endmodule

// File: rtl/opmul_chk.sv
module opmul_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         a_ld,
   input logic         b_ld,
   input logic         hi_ld,
   input logic         lo_ld,
   input logic         bypass,
   input logic         sel_lo,
   input logic         hi_oe_n,
   input logic         lo_oe_n,
   input logic [W-1:0] hi_bus,
   input logic [W-1:0] lo_bus,
   input logic [W-1:0] hi_q_w,
   input logic [W-1:0] lo_q_w,
   input logic         rnd_q,
   input logic [W-1:0] msp_w
);

   // R5: output registers hold without their strobe
   assert_hi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_ld |=> $stable(hi_q_w));
   assert_lo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_ld |=> $stable(lo_q_w));

   // R3: round bit changes only on an operand load
   assert_rnd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_ld || b_ld) |=> $stable(rnd_q));

   // R6: what bypass shows is what the register captures
   assert_bypass_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && hi_ld) |=> (hi_q_w == $past(msp_w)));

   // R7: with both ports driven and the lower half selected, ports agree
   assert_sel_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_oe_n && !lo_oe_n && sel_lo) |-> (hi_bus == lo_bus));

   // R9: reset leaves every output register and the round bit clear
   assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |=> (hi_q_w == '0 && lo_q_w == '0 && !rnd_q));

endmodule

bind opmul_top opmul_chk #(.W(OPW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_ld    (a_ld),
   .b_ld    (b_ld),
   .hi_ld   (hi_ld),
   .lo_ld   (lo_ld),
   .bypass  (bypass),
   .sel_lo  (sel_lo),
   .hi_oe_n (hi_oe_n),
   .lo_oe_n (lo_oe_n),
   .hi_bus  (hi_bus),
   .lo_bus  (lo_bus),
   .hi_q_w  (hi_q_w),
   .lo_q_w  (lo_q_w),
   .rnd_q   (rnd_q),
   .msp_w   (msp_w)
);

// File: tb/tb_opmul_top.sv
`timescale 1ns/1ps
module tb_opmul_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] a_in;
   logic        a_ld, b_ld, a_sgn, b_sgn, rnd_req, fmt_adj;
   logic        hi_ld, lo_ld, bypass, sel_lo, lo_oe_n, hi_oe_n;
   logic [15:0] y_drv;
   logic        y_en;
   wire  [15:0] lo_bus;
   logic [15:0] hi_bus;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   assign lo_bus = y_en ? y_drv : 16'hzzzz;

   opmul_top dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ld(a_ld), .b_ld(b_ld),
      .a_sgn(a_sgn), .b_sgn(b_sgn), .rnd_req(rnd_req), .fmt_adj(fmt_adj),
      .hi_ld(hi_ld), .lo_ld(lo_ld), .bypass(bypass), .sel_lo(sel_lo),
      .lo_oe_n(lo_oe_n), .hi_oe_n(hi_oe_n), .lo_bus(lo_bus), .hi_bus(hi_bus)
   );

   // reference: exact product of extended operands, then round and format
   function automatic logic [31:0] ref_res(input logic [15:0] x, input logic [15:0] y,
                                           input logic xs, input logic ys,
                                           input logic r, input logic f);
      logic [63:0] xv, yv, pv;
      logic [31:0] s;
      xv = xs ? {{48{x[15]}}, x} : {48'd0, x};
      yv = ys ? {{48{y[15]}}, y} : {48'd0, y};
      pv = xv * yv;
      s  = pv[31:0] + (r ? (f ? 32'h0000_8000 : 32'h0000_4000) : 32'd0);
      if (f) return s;
      return {s[30:15], s[31], s[13:0], 1'b0};
   endfunction

   function automatic logic [15:0] opv(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h7fff;
         3: return 16'h8000;
         4: return 16'hffff;
         5: return 16'h0002;
         6: return 16'h8001;
         default: return 16'h5a3c;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_ops(input logic [15:0] x, input logic [15:0] y,
                           input logic xs, input logic ys, input logic r,
                           input logic f, input logic doa, input logic dob);
      @(negedge clk);
      lo_oe_n = 1'b1; hi_oe_n = 1'b1;
      a_in = x; y_drv = y; y_en = 1'b1;
      a_ld = doa; b_ld = dob; rnd_req = r;
      a_sgn = xs; b_sgn = ys; fmt_adj = f;
      @(negedge clk);
      a_ld = 1'b0; b_ld = 1'b0; y_en = 1'b0;
   endtask

   task automatic load_out(input logic h, input logic l);
      hi_ld = h; lo_ld = l;
      @(negedge clk);
      hi_ld = 1'b0; lo_ld = 1'b0;
   endtask

   task automatic peek(input string tag, input logic [15:0] eh, input logic [15:0] el);
      hi_oe_n = 1'b0; lo_oe_n = 1'b0; sel_lo = 1'b0;
      #1;
      chk({tag, " upper"}, hi_bus, eh);
      chk({tag, " lower"}, lo_bus, el);
      sel_lo = 1'b1;
      #1;
      chk({tag, "/R7 sel"}, hi_bus, el);
      sel_lo = 1'b0; lo_oe_n = 1'b1; hi_oe_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] e, e1, e2, e3;
      logic [15:0] lx, ly;
      rst_n = 1'b0; a_in = '0; a_ld = 0; b_ld = 0; a_sgn = 0; b_sgn = 0;
      rnd_req = 0; fmt_adj = 1; hi_ld = 0; lo_ld = 0; bypass = 0; sel_lo = 0;
      lo_oe_n = 1; hi_oe_n = 1; y_drv = '0; y_en = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: cleared registers and round bit
      peek("R9 regs", 16'h0000, 16'h0000);
      bypass = 1'b1;
      peek("R9 comb", 16'h0000, 16'h0000);
      bypass = 1'b0;

      // R1 R3 R4 R8: full mode sweep over corner operands (Y arrives on lo_bus)
      for (int m = 0; m < 16; m++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               e = ref_res(opv(i), opv(j), m[0], m[1], m[2], m[3]);
               load_ops(opv(i), opv(j), m[0], m[1], m[2], m[3], 1'b1, 1'b1);
               load_out(1'b1, 1'b1);
               if (m[2])       peek("R3 round", e[31:16], e[15:0]);
               else if (!m[3]) peek("R4 fract", e[31:16], e[15:0]);
               else            peek("R1/R8 prod", e[31:16], e[15:0]);
            end
         end
      end

      // R2: each operand register loads only on its own strobe
      load_ops(16'h0123, 16'h0456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      load_ops(16'h0f0f, 16'hffff, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      load_out(1'b1, 1'b1);
      e = ref_res(16'h0f0f, 16'h0456, 1'b1, 1'b1, 1'b0, 1'b1);
      peek("R2 x-only", e[31:16], e[15:0]);
      load_ops(16'hdead, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      load_out(1'b1, 1'b1);
      e = ref_res(16'h0f0f, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b1);
      peek("R2 y-only", e[31:16], e[15:0]);

      // R3: round bit holds between loads, recaptured on a Y-only load
      load_ops(16'h4000, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      rnd_req = 1'b0;
      @(negedge clk);
      load_out(1'b1, 1'b1);
      e = ref_res(16'h4000, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b1);
      peek("R3 hold", e[31:16], e[15:0]);
      load_ops(16'h0000, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      load_out(1'b1, 1'b1);
      e = ref_res(16'h4000, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b1);
      peek("R3 recapture", e[31:16], e[15:0]);

      // R5: independent output register loads
      e1 = e;
      load_ops(16'hfff3, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      e2 = ref_res(16'hfff3, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1);
      load_out(1'b1, 1'b0);
      peek("R5 hi-only", e2[31:16], e1[15:0]);
      load_out(1'b0, 1'b1);
      peek("R5 lo-only", e2[31:16], e2[15:0]);

      // R6: bypass follows operands with no output load, registers kept
      load_ops(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      e3 = ref_res(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0);
      bypass = 1'b1;
      peek("R6 bypass", e3[31:16], e3[15:0]);
      bypass = 1'b0;
      peek("R6 kept", e2[31:16], e2[15:0]);

      // R1 R3 R4: pseudo-random operands and modes
      lx = 16'hace1; ly = 16'h1d2b;
      for (int k = 0; k < 300; k++) begin
         logic [3:0] md;
         lx = {lx[14:0], lx[15] ^ lx[13] ^ lx[12] ^ lx[10]};
         ly = {ly[14:0], ly[15] ^ ly[13] ^ ly[12] ^ ly[10]};
         md = lx[3:0] ^ ly[7:4];
         e = ref_res(lx, ly, md[0], md[1], md[2], md[3]);
         load_ops(lx, ly, md[0], md[1], md[2], md[3], 1'b1, 1'b1);
         load_out(1'b1, 1'b1);
         peek("R1/R3/R4 random", e[31:16], e[15:0]);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule